// File: doc/BRIEF.md
# Requester-Filtered Address Remap Windows

This block relocates system addresses through a bank of programmable remap windows. Each request carries a 64-bit address and an identity: either the control core or one of eight sequencer cores. Every window holds four items: a control word, a 20-bit mask, a 20-bit match key and a 44-bit replacement page. A window compares only address bits [39:20], so it acts on 1 MiB aligned pages. A window hits when three things hold: it is enabled, the requester's identity passes its class filter, and the masked page bits equal the masked match key.

On a hit, the block returns the replacement page in bits [63:20] and keeps the incoming offset bits [19:0]. On a miss, the address comes back unchanged and a miss flag is raised. If several windows hit, the one with the lowest index wins. Software programs the windows one field at a time through a simple write port. It clears a window's enable bit before it edits the window and sets the bit again as the last step.

Top module: `remap_window_bank`

## Requirements
- R1: There are NUM_WIN (default 40) windows, selected by `wr_win`. When `wr_en` is high, `wr_field` picks the target field: 0 selects the control word (`wr_data[6:0]`), 1 the mask (`wr_data[19:0]`, covering address bits [39:20]), 2 the match key (`wr_data[19:0]`) and 3 the replacement (`wr_data[43:0]`, covering address bits [63:20]). A write takes effect from the next cycle. A lookup made in the same cycle as a write sees the state from before that write.
- R2: The control word is laid out as follows: bit 0 enables the window; bit 1 restricts it to the control core; bit 2 restricts it to sequencers; bit 3 restricts it to one sequencer; bits [6:4] give that sequencer's number.
- R3: The page test is `((req_addr[39:20] ^ match) & mask) == 0`. Address bits [19:0] and [63:40] play no part in the test.
- R4: On a hit, `rsp_addr` equals {replacement, `req_addr[19:0]`}.
- R5: A window whose enable bit is 0 never hits, whatever its other fields hold.
- R6: After reset, every field of every window is 0, so every request misses, and all response outputs are 0 until the first request.
- R7: A requester is the control core when `req_is_seq` is 0 and sequencer `req_seq_id` when it is 1. A window with the control-core-only bit set is hit only by the control core. A window with the sequencer-only bit set is hit only by sequencers.
- R8: A window with the single-sequencer bit set is hit only when `req_is_seq` is 1 and `req_seq_id` equals bits [6:4]. When the single-sequencer bit is 0, bits [6:4] have no effect.
- R9: When several windows hit, the lowest-numbered one is used, and its index appears on `rsp_win`.
- R10: On a miss, `rsp_miss` is 1, `rsp_hit` is 0, `rsp_win` is 0 and `rsp_addr` equals `req_addr`. A valid response has exactly one of `rsp_hit` and `rsp_miss` set.
- R11: The response appears one cycle after the request. `rsp_valid` follows `req_valid`. A cycle with no request yields, one cycle later, `rsp_valid`, `rsp_hit` and `rsp_miss` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Window field write strobe |
| wr_win | input | 6 | Index of the window written |
| wr_field | input | 2 | Field selector (0 control, 1 mask, 2 match, 3 replacement) |
| wr_data | input | 44 | Write value, aligned to bit 0 |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 64 | Address to translate |
| req_is_seq | input | 1 | 1 when the requester is a sequencer, 0 for the control core |
| req_seq_id | input | 3 | Sequencer number, used when `req_is_seq` is 1 |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_hit | output | 1 | A window translated the address |
| rsp_miss | output | 1 | No window hit |
| rsp_win | output | 6 | Index of the winning window (0 on a miss) |
| rsp_addr | output | 64 | Translated or pass-through address |

## Verification
Some properties are checked on every cycle. On the response side these are: the one-cycle latency of `rsp_valid`, the exclusive hit/miss flags, offset preservation on a hit and unchanged addresses on a miss. Inside the selector these are: a one-hot grant, that the grant is the lowest hit, and that a hit implies an enabled window whose class filter and single-sequencer test passed. Other behaviours appear only in the bench's scenarios, which are checked against a behavioural model. These are: the correct replacement value, partial masks that ignore some page bits, a write made in the same cycle as a lookup, the reset state, disabling a winning window so that the next window takes over, and the select field having no effect while its enable bit is clear.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int PAGE_LSB = 20;
    localparam int KEY_MSB  = 39;
    localparam int KEY_W    = KEY_MSB - PAGE_LSB + 1;
    localparam int SEQ_ID_W = 3;
    localparam int CTRL_W   = 4 + SEQ_ID_W;

    // bit 0 is the enable; layout is software-visible
    typedef struct packed {
        logic [SEQ_ID_W-1:0] seq_sel;
        logic                one_seq;
        logic                seq_only;
        logic                cc_only;
        logic                valid;
    } win_ctrl_t;

    typedef enum logic [1:0] {
        FLD_CTRL  = 2'd0,
        FLD_MASK  = 2'd1,
        FLD_MATCH = 2'd2,
        FLD_REPL  = 2'd3
    } win_field_e;
endpackage

// File: rtl/remap_win_regs.sv
module remap_win_regs
    import remap_pkg::*;
#(
    parameter int NUM_WIN = 40,
    parameter int REPL_W  = 44,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_win,
    input  win_field_e          wr_field,
    input  logic [REPL_W-1:0]   wr_data,
    output win_ctrl_t           ctrl_o  [NUM_WIN],
    output logic [KEY_W-1:0]    mask_o  [NUM_WIN],
    output logic [KEY_W-1:0]    match_o [NUM_WIN],
    output logic [REPL_W-1:0]   repl_o  [NUM_WIN]
);
    typedef struct packed {
        win_ctrl_t          ctrl;
        logic [KEY_W-1:0]   mask;
        logic [KEY_W-1:0]   match;
        logic [REPL_W-1:0]  repl;
    } slot_t;

    slot_t slot_d [NUM_WIN];
    slot_t slot_q [NUM_WIN];

    always_comb begin
        for (int w = 0; w < NUM_WIN; w++) begin
            slot_d[w] = slot_q[w];
        end
        if (wr_en && (int'(wr_win) < NUM_WIN)) begin
            case (wr_field)
                FLD_CTRL:  slot_d[wr_win].ctrl  = win_ctrl_t'(wr_data[CTRL_W-1:0]);
                FLD_MASK:  slot_d[wr_win].mask  = wr_data[KEY_W-1:0];
                FLD_MATCH: slot_d[wr_win].match = wr_data[KEY_W-1:0];
                default:   slot_d[wr_win].repl  = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                slot_q[w] <= '0;
            end
        end else begin
            for (int w = 0; w < NUM_WIN; w++) begin
                slot_q[w] <= slot_d[w];
            end
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
        assign ctrl_o[g]  = slot_q[g].ctrl;
        assign mask_o[g]  = slot_q[g].mask;
        assign match_o[g] = slot_q[g].match;
        assign repl_o[g]  = slot_q[g].repl;
    end
endmodule

// File: rtl/remap_win_match.sv
module remap_win_match
    import remap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  win_ctrl_t           ctrl,
    input  logic [KEY_W-1:0]    mask,
    input  logic [KEY_W-1:0]    match,
    input  logic [KEY_W-1:0]    req_key,
    input  logic                req_is_seq,
    input  logic [SEQ_ID_W-1:0] req_seq_id,
    output logic                hit_o
);
    logic cls_ok;
    logic key_ok;

    always_comb begin
        cls_ok = 1'b1;
        if (ctrl.cc_only && req_is_seq) begin
            cls_ok = 1'b0;
        end
        if (ctrl.seq_only && !req_is_seq) begin
            cls_ok = 1'b0;
        end
        if (ctrl.one_seq && !(req_is_seq && (req_seq_id == ctrl.seq_sel))) begin
            cls_ok = 1'b0;
        end
        key_ok = ((req_key ^ match) & mask) == '0;
        hit_o  = ctrl.valid && cls_ok && key_ok;
    end

    // R5
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ctrl.valid);

    // R8
    one_seq_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && ctrl.one_seq) |-> (req_is_seq && req_seq_id == ctrl.seq_sel));

    // R7
    class_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !(ctrl.cc_only && req_is_seq) && !(ctrl.seq_only && !req_is_seq));
endmodule

// File: rtl/remap_prio_pick.sv
module remap_prio_pick #(
    parameter int N      = 40,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     hits,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        gnt = hits & (~hits + N'(1));
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |hits;
    end

    // R9
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt != '0) == (hits != '0)));

    // R9
    gnt_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> (((gnt - N'(1)) & hits) == '0) && ((gnt & hits) == gnt));
endmodule

// File: rtl/remap_window_bank.sv
module remap_window_bank
    import remap_pkg::*;
#(
    parameter int NUM_WIN = 40,
    parameter int ADDR_W  = 64,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int REPL_W = ADDR_W - PAGE_LSB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_win,
    input  logic [1:0]          wr_field,
    input  logic [REPL_W-1:0]   wr_data,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_is_seq,
    input  logic [SEQ_ID_W-1:0] req_seq_id,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic [IDX_W-1:0]    rsp_win,
    output logic [ADDR_W-1:0]   rsp_addr
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic [IDX_W-1:0]  win;
        logic [ADDR_W-1:0] addr;
    } rsp_t;

    win_ctrl_t          ctrl  [NUM_WIN];
    logic [KEY_W-1:0]   mask  [NUM_WIN];
    logic [KEY_W-1:0]   match [NUM_WIN];
    logic [REPL_W-1:0]  repl  [NUM_WIN];
    logic [NUM_WIN-1:0] hits;
    logic [NUM_WIN-1:0] gnt;
    logic [IDX_W-1:0]   win_idx;
    logic               any_hit;
    rsp_t               rsp_d;
    rsp_t               rsp_q;

    remap_win_regs #(.NUM_WIN(NUM_WIN), .REPL_W(REPL_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_win   (wr_win),
        .wr_field (win_field_e'(wr_field)),
        .wr_data  (wr_data),
        .ctrl_o   (ctrl),
        .mask_o   (mask),
        .match_o  (match),
        .repl_o   (repl)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        remap_win_match i_match (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl       (ctrl[g]),
            .mask       (mask[g]),
            .match      (match[g]),
            .req_key    (req_addr[KEY_MSB:PAGE_LSB]),
            .req_is_seq (req_is_seq),
            .req_seq_id (req_seq_id),
            .hit_o      (hits[g])
        );
    end

    remap_prio_pick #(.N(NUM_WIN)) i_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .hits  (hits),
        .gnt   (gnt),
        .idx   (win_idx),
        .any   (any_hit)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.addr  = req_addr;
        if (req_valid) begin
            if (any_hit) begin
                rsp_d.hit  = 1'b1;
                rsp_d.win  = win_idx;
                rsp_d.addr = {repl[win_idx], req_addr[PAGE_LSB-1:0]};
            end else begin
                rsp_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_win   = rsp_q.win;
    assign rsp_addr  = rsp_q.addr;

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

    // R10
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R10
    miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_addr == $past(req_addr) && rsp_win == '0));

    // R4
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_addr[PAGE_LSB-1:0] == $past(req_addr[PAGE_LSB-1:0])));
endmodule

// File: tb/test_remap_window_bank.sv
module test_remap_window_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_win = '0;
    logic [1:0]  wr_field = '0;
    logic [43:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_is_seq = 1'b0;
    logic [2:0]  req_seq_id = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [5:0]  rsp_win;
    logic [63:0] rsp_addr;

    remap_window_bank i_remap_window_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
        .wr_field(wr_field), .wr_data(wr_data), .req_valid(req_valid),
        .req_addr(req_addr), .req_is_seq(req_is_seq), .req_seq_id(req_seq_id),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_addr(rsp_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural model of window contents
    logic [6:0]  m_ctrl  [NW];
    logic [19:0] m_mask  [NW];
    logic [19:0] m_match [NW];
    logic [43:0] m_repl  [NW];

    bit          pend = 0;
    string       pend_tag;
    logic        e_valid, e_hit, e_miss;
    logic [5:0]  e_win;
    logic [63:0] e_addr;

    task automatic check_prev();
        bit bad;
        if (!pend) return;
        checks++;
        bad = (rsp_valid !== e_valid) || (rsp_hit !== e_hit) || (rsp_miss !== e_miss);
        if (e_valid && ((rsp_win !== e_win) || (rsp_addr !== e_addr))) bad = 1;
        if (bad) begin
            fails++;
            $display("FAIL %s: got v=%b h=%b m=%b w=%0d a=%h, expected v=%b h=%b m=%b w=%0d a=%h",
                     pend_tag, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_addr,
                     e_valid, e_hit, e_miss, e_win, e_addr);
        end
        pend = 0;
    endtask

    task automatic step(input bit we, input int win, input int fld, input logic [43:0] wd,
                        input bit rv, input logic [63:0] ra, input bit seq, input int sid,
                        input string tag);
        @(negedge clk);
        check_prev();
        wr_en = we; wr_win = 6'(win); wr_field = 2'(fld); wr_data = wd;
        req_valid = rv; req_addr = ra; req_is_seq = seq; req_seq_id = 3'(sid);
        // expectation from pre-write model state
        e_valid = rv; e_hit = 0; e_miss = rv; e_win = '0; e_addr = ra;
        if (rv) begin
            for (int w = 0; w < NW; w++) begin
                bit ok;
                ok = m_ctrl[w][0];
                if (m_ctrl[w][1] && seq) ok = 0;
                if (m_ctrl[w][2] && !seq) ok = 0;
                if (m_ctrl[w][3] && !(seq && m_ctrl[w][6:4] == 3'(sid))) ok = 0;
                if (((ra[39:20] ^ m_match[w]) & m_mask[w]) != 20'h0) ok = 0;
                if (ok) begin
                    e_hit = 1; e_miss = 0; e_win = 6'(w);
                    e_addr = {m_repl[w], ra[19:0]};
                    break;
                end
            end
        end
        if (we && win < NW) begin
            case (fld)
                0: m_ctrl[win]  = wd[6:0];
                1: m_mask[win]  = wd[19:0];
                2: m_match[win] = wd[19:0];
                default: m_repl[win] = wd;
            endcase
        end
        pend = 1; pend_tag = tag;
    endtask

    task automatic wr(input int win, input int fld, input logic [43:0] wd, input string tag);
        step(1, win, fld, wd, 0, '0, 0, 0, tag);
    endtask

    task automatic rq(input logic [63:0] ra, input bit seq, input int sid, input string tag);
        step(0, 0, 0, '0, 1, ra, seq, sid, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, '0, 0, '0, 0, 0, tag);
    endtask

    initial begin
        for (int w = 0; w < NW; w++) begin
            m_ctrl[w] = '0; m_mask[w] = '0; m_match[w] = '0; m_repl[w] = '0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: outputs idle after reset
        checks++;
        if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || rsp_win !== 0 || rsp_addr !== 0) begin
            fails++;
            $display("FAIL R6: got v=%b h=%b m=%b w=%0d a=%h, expected all zero",
                     rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_addr);
        end
        // R6: every request misses after reset
        rq(64'h0, 0, 0, "R6");
        rq(64'hFFFF_FFFF_FFFF_FFFF, 1, 7, "R6");
        rq(64'h1234_5678_9ABC_DEF0, 1, 2, "R6");

        // R5: fields programmed with enable clear: no hit
        wr(5, 0, 44'h0, "R5");
        wr(5, 1, 44'hFFFFF, "R5");
        wr(5, 2, 44'h12345, "R5");
        wr(5, 3, 44'hABC_DEF0_1234, "R5");
        rq(64'hDEAD_0012_3456_789A, 0, 0, "R5");
        // R1: enable written in same cycle as lookup -> old state
        step(1, 5, 0, 44'h1, 1, 64'hDEAD_0012_3456_789A, 0, 0, "R1");
        // R4: hit replaces page, keeps offset
        rq(64'hDEAD_0012_3456_789A, 0, 0, "R4");
        rq(64'h0000_0012_345F_FFFF, 1, 4, "R4");
        // R10: non-matching page misses
        rq(64'hDEAD_0012_3556_789A, 0, 0, "R10");
        // R3: partial mask ignores low page bits and upper address bits
        wr(5, 1, 44'hFFF00, "R3");
        rq(64'h7777_0012_3FF0_0001, 1, 1, "R3");
        rq(64'h0000_0013_3450_0000, 0, 0, "R3");
        // R11: idle cycles between requests
        idle("R11");
        rq(64'h0000_0012_3450_0000, 0, 0, "R11");
        idle("R11");
        idle("R11");

        // R9: two windows hit, lowest wins
        wr(3, 1, 44'hFFFFF, "R9");
        wr(3, 2, 44'h12345, "R9");
        wr(3, 3, 44'h111_2222_3333, "R9");
        wr(3, 0, 44'h1, "R9");
        rq(64'h0000_0012_3456_0000, 0, 0, "R9");
        // R5: clearing window 3 hands over to window 5
        wr(3, 0, 44'h0, "R5");
        rq(64'h0000_0012_3456_0000, 0, 0, "R5");
        // R2: window 39 with both other bits unused
        wr(39, 1, 44'h0, "R2");
        wr(39, 3, 44'hFFF_FFFF_FFFF, "R2");
        wr(39, 0, 44'h1, "R2");
        rq(64'h0000_00FF_F000_0ABC, 1, 0, "R2");

        // R7: control-core-only and sequencer-only
        wr(39, 0, 44'h0, "R7");
        wr(10, 1, 44'hFFFFF, "R7");
        wr(10, 2, 44'h00ABC, "R7");
        wr(10, 3, 44'h555_0000_0005, "R7");
        wr(10, 0, 44'h03, "R7");
        rq(64'h0000_0000_ABC0_1234, 0, 0, "R7");
        rq(64'h0000_0000_ABC0_1234, 1, 3, "R7");
        wr(10, 0, 44'h05, "R7");
        rq(64'h0000_0000_ABC0_1234, 0, 0, "R7");
        rq(64'h0000_0000_ABC0_1234, 1, 0, "R7");
        // R8: single sequencer 6
        wr(10, 0, 44'h69, "R8");
        rq(64'h0000_0000_ABC0_1234, 1, 6, "R8");
        rq(64'h0000_0000_ABC0_1234, 1, 2, "R8");
        rq(64'h0000_0000_ABC0_1234, 0, 6, "R8");
        // R8: select without enable has no effect
        wr(10, 0, 44'h61, "R8");
        rq(64'h0000_0000_ABC0_1234, 1, 2, "R8");
        rq(64'h0000_0000_ABC0_1234, 0, 0, "R8");

        // R9: random traffic over a small key space
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] a;
            int fld;
            logic [43:0] d;
            int win;
            a = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0) a[39:20] = 20'($urandom_range(0, 3));
            fld = $urandom_range(0, 3);
            win = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 7) : $urandom_range(36, 41);
            d = {$urandom, $urandom};
            if (fld == 0) d = 44'($urandom_range(0, 127));
            if (fld == 1) d = ($urandom_range(0, 2) == 0) ? 44'h0 : 44'hFFFFF;
            if (fld == 2) d = 44'($urandom_range(0, 3));
            step($urandom_range(0, 2) == 0, win, fld, d, $urandom_range(0, 3) != 0, a,
                 1'($urandom_range(0, 1)), $urandom_range(0, 7), "R9");
        end
        idle("R11");
        idle("R11");
        @(negedge clk);
        check_prev();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected end of scenarios");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule